// File: doc/BRIEF.md
# Background Refresh Walker With Port Arbitration

This block sits between a single requester and a word-organized storage array that keeps its contents only if every location is rewritten from time to time. With no command from the requester, it walks the array one location at a time. For each location it reads the stored word and then writes that same word back. A programmable interval sets how often a refresh step falls due.

The array has one port, shared by the refresh walker and the requester, and the block decides which of them drives it in each cycle. A due refresh step that is not yet late takes the port only when the requester is not asking for it. After it has waited a fixed number of cycles, it takes priority over new requests. The block also enforces a separate minimum recovery time after each array read and after each array write. The array is an ordinary synchronous RAM with one cycle of read latency.

Top module: `refresh_arbiter`

## Requirements
- R1: After reset, `ready` is 1, `mem_en` is 0 and `rvalid` is 0.
- R2: A refresh step falls due every `rf_interval`+1 cycles, whether or not the requester is active. When the requester is idle, successive refresh reads on the array port are exactly `rf_interval`+1 cycles apart, provided that spacing is at least `RD_CYC`+`WR_CYC` cycles.
- R3: Refresh reads visit locations in ascending order, starting at 0 after reset. After location `DEPTH`-1 the next is 0, including when `DEPTH` is not a power of two.
- R4: Each refresh read is followed by exactly one refresh write. That write goes to the same location and carries the word the read returned, which is the word last stored there.
- R5: The requester and the walker never issue on the array port in the same cycle. `ready` is 0 from the cycle after a refresh read up to and including the cycle of its write-back. A request held during that time is accepted later.
- R6: After an array read, the next array operation comes at least `RD_CYC` cycles later. After an array write, the next comes at least `WR_CYC` cycles later.
- R7: A refresh step that has been due for fewer than `LATE_LIMIT` cycles yields to a present request. Once it has been due that long, `ready` goes to 0 and the refresh step takes the port next, even under continuous requests.
- R8: A request with `we`=0 is accepted at a rising edge where `req` and `ready` are both 1. Two cycles after the accepting cycle, `rvalid` is 1 for one cycle and `rdata` holds the word last written at `addr`. In all other cycles `rvalid` is 0.
- R9: An accepted request drives the array port in its accepting cycle: `mem_en`=1, `mem_we`=`we`, `mem_addr`=`addr`. When `we`=1, `mem_wdata`=`wdata` and that word is stored.
- R10: While `rf_interval` is held constant, no location goes longer than `DEPTH`*(`rf_interval`+1)+`LATE_LIMIT`+`RD_CYC`+`WR_CYC`+2 cycles between two refresh reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rf_interval | input | IW | Refresh spacing minus one, in cycles |
| req | input | 1 | Requester asks for an array operation |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word location of the request |
| wdata | input | DW | Write word |
| ready | output | 1 | A request is accepted in this cycle if `req` is 1 |
| rdata | output | DW | Read word, valid while `rvalid` is 1 |
| rvalid | output | 1 | Read result strobe |
| mem_en | output | 1 | Array operation this cycle |
| mem_we | output | 1 | Array write when 1 |
| mem_addr | output | AW | Array location |
| mem_wdata | output | DW | Array write word |
| mem_rdata | input | DW | Array read word, one cycle after the read |

## Verification
The assertions check these properties on every cycle:
- the requester and the walker never issue on the port together, and `ready` stays low while a refresh owns the port;
- the recovery spacing after reads and after writes is respected;
- refresh reads follow the wrapping address order, and each write-back matches its read in location and data;
- read results appear two cycles after acceptance;
- a late refresh step blocks new requests.

Only the bench scenarios can show the rest. These are the exact refresh period under two interval settings, the refresh progress forced through a continuous stream of reads, the per-location refresh deadline, and data integrity against a model while random traffic is mixed with refresh.

// File: rtl/rfa_pkg.sv
package rfa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_PUT   = 2'd2
  } walk_state_t;

  // recovery cycles to wait after an operation, beyond the issue cycle
  function automatic int unsigned recov_count(input logic is_wr,
                                              input int unsigned rd_cyc,
                                              input int unsigned wr_cyc);
    return (is_wr ? wr_cyc : rd_cyc) - 1;
  endfunction

  // next refresh location with wrap at an arbitrary depth
  function automatic int unsigned next_loc(input int unsigned loc,
                                           input int unsigned depth);
    return (loc + 1 >= depth) ? 0 : loc + 1;
  endfunction

endpackage

// File: rtl/rfa_pacer.sv
module rfa_pacer #(
  parameter int IW         = 8,
  parameter int LATE_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] interval,
  input  logic          consume,
  output logic          pending,
  output logic          urgent
);
  localparam int LW = $clog2(LATE_LIMIT + 1) > 0 ? $clog2(LATE_LIMIT + 1) : 1;

  logic [IW-1:0] tick_q;
  logic [LW-1:0] age_q;
  logic          pend_q;
  logic          tick_hit;

  assign tick_hit = (tick_q >= interval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      pend_q <= 1'b0;
    end else begin
      tick_q <= tick_hit ? '0 : tick_q + 1'b1;
      if (tick_hit)     pend_q <= 1'b1;
      else if (consume) pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (!pend_q || consume) begin
      age_q <= '0;
    end else if (age_q != LW'(LATE_LIMIT)) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign pending = pend_q;
  assign urgent  = pend_q && (age_q == LW'(LATE_LIMIT));

endmodule

// File: rtl/rfa_recovery.sv
module rfa_recovery #(
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic op_fire,
  input  logic op_is_wr,
  output logic free
);
  localparam int MAXC = (RD_CYC > WR_CYC) ? RD_CYC : WR_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (op_fire)        cnt_q <= CW'(rfa_pkg::recov_count(op_is_wr, RD_CYC, WR_CYC));
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign free = (cnt_q == '0);

endmodule

// File: rtl/refresh_arbiter.sv
module refresh_arbiter #(
  parameter int DEPTH      = 16,
  parameter int DW         = 16,
  parameter int IW         = 8,
  parameter int LATE_LIMIT = 8,
  parameter int RD_CYC     = 2,
  parameter int WR_CYC     = 3,
  localparam int AW        = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] rf_interval,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  import rfa_pkg::*;

  walk_state_t   state_q;
  logic [AW-1:0] rf_addr_q;
  logic [DW-1:0] hold_q;
  logic [DW-1:0] rdata_q;
  logic          rd_pend_q;
  logic          rvalid_q;

  // named internal events
  logic          pending;
  logic          urgent;
  logic          port_free;
  logic          walk_idle;
  logic          rq_issue;
  logic          rf_rd_issue;
  logic          rf_wr_issue;
  logic [DW-1:0] wb_data;

  rfa_pacer #(.IW(IW), .LATE_LIMIT(LATE_LIMIT)) u_pacer (
    .clk      (clk),
    .rst_n    (rst_n),
    .interval (rf_interval),
    .consume  (rf_rd_issue),
    .pending  (pending),
    .urgent   (urgent)
  );

  rfa_recovery #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC)) u_recov (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_fire  (mem_en),
    .op_is_wr (mem_we),
    .free     (port_free)
  );

  assign walk_idle   = (state_q == ST_IDLE);
  assign ready       = walk_idle && port_free && !urgent;
  assign rq_issue    = req && ready;
  assign rf_rd_issue = walk_idle && port_free && pending && (urgent || !req);
  assign rf_wr_issue = !walk_idle && port_free;
  assign wb_data     = (state_q == ST_FETCH) ? mem_rdata : hold_q;

  assign mem_en    = rq_issue || rf_rd_issue || rf_wr_issue;
  assign mem_we    = rq_issue ? we    : rf_wr_issue;
  assign mem_addr  = rq_issue ? addr  : rf_addr_q;
  assign mem_wdata = rq_issue ? wdata : wb_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rf_addr_q <= '0;
      hold_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (rf_rd_issue) state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          hold_q  <= mem_rdata;
          state_q <= port_free ? ST_IDLE : ST_PUT;
        end
        ST_PUT: begin
          if (port_free) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (rf_wr_issue)
        rf_addr_q <= AW'(next_loc(int'(rf_addr_q), DEPTH));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= 1'b0;
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
    end else begin
      rd_pend_q <= rq_issue && !we;
      rvalid_q  <= rd_pend_q;
      if (rd_pend_q) rdata_q <= mem_rdata;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/rfa_checker.sv
module rfa_checker #(
  parameter int DEPTH  = 16,
  parameter int DW     = 16,
  parameter int RD_CYC = 2,
  parameter int WR_CYC = 3,
  localparam int AW    = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready,
  input logic          rvalid,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [DW-1:0] mem_rdata,
  input logic          rq_issue,
  input logic          rq_rd,
  input logic          rf_rd_issue,
  input logic          rf_wr_issue,
  input logic          walk_idle,
  input logic          urgent
);
  logic [7:0]    since_q;
  logic          last_wr_q;
  logic [AW-1:0] exp_loc_q;
  logic [AW-1:0] rd_loc_q;
  logic [DW-1:0] rd_word_q;
  logic          fetch_q;
  int            need;

  assign need = last_wr_q ? WR_CYC : RD_CYC;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_q   <= 8'hff;
      last_wr_q <= 1'b0;
      exp_loc_q <= '0;
      rd_loc_q  <= '0;
      rd_word_q <= '0;
      fetch_q   <= 1'b0;
    end else begin
      if (mem_en) begin
        since_q   <= 8'd1;
        last_wr_q <= mem_we;
      end else if (since_q != 8'hff) begin
        since_q <= since_q + 8'd1;
      end
      if (rf_rd_issue) begin
        rd_loc_q  <= mem_addr;
        exp_loc_q <= (int'(exp_loc_q) == DEPTH - 1) ? '0 : exp_loc_q + 1'b1;
      end
      fetch_q <= rf_rd_issue;
      if (fetch_q) rd_word_q <= mem_rdata;
    end
  end

  AST_PORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rq_issue && (rf_rd_issue || rf_wr_issue)));                     // R5
  AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !walk_idle |-> !ready);                                           // R5
  AST_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (int'(since_q) >= need));                              // R6
  AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_issue |-> (mem_addr == exp_loc_q));                         // R3
  AST_WB_LOC: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr_issue |-> (mem_we && mem_addr == rd_loc_q));                // R4
  AST_WB_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr_issue && !fetch_q) |-> (mem_wdata == rd_word_q));          // R4
  AST_LATE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> !ready);                                               // R7
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_issue && rq_rd) |=> ##1 rvalid);                              // R8
  AST_RVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |=> !rvalid || $past(rq_issue && rq_rd));                  // R8

endmodule

bind refresh_arbiter rfa_checker #(
  .DEPTH(DEPTH), .DW(DW), .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)
) u_rfa_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready       (ready),
  .rvalid      (rvalid),
  .mem_en      (mem_en),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .mem_rdata   (mem_rdata),
  .rq_issue    (rq_issue),
  .rq_rd       (!we),
  .rf_rd_issue (rf_rd_issue),
  .rf_wr_issue (rf_wr_issue),
  .walk_idle   (walk_idle),
  .urgent      (urgent)
);

// File: tb/tb_refresh_arbiter.sv
module tb_refresh_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 12;
  localparam int DW         = 16;
  localparam int IW         = 8;
  localparam int LATE_LIMIT = 8;
  localparam int RD_CYC     = 2;
  localparam int WR_CYC     = 3;
  localparam int AW         = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [IW-1:0] rf_interval = 8'd10;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, rvalid, mem_en, mem_we;
  logic [DW-1:0] rdata, mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] mem_addr;

  logic [DW-1:0] ram   [DEPTH];
  logic [DW-1:0] model [DEPTH];

  int vectors = 0;
  int fails   = 0;
  int epoch   = 0;
  bit meas_on = 0;
  bit mon_on  = 0;
  bit done    = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  refresh_arbiter #(
    .DEPTH(DEPTH), .DW(DW), .IW(IW), .LATE_LIMIT(LATE_LIMIT),
    .RD_CYC(RD_CYC), .WR_CYC(WR_CYC)
  ) dut (
    .clk(clk), .rst_n(rst_n), .rf_interval(rf_interval),
    .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .rdata(rdata), .rvalid(rvalid),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // synchronous single-port array
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
    end
  end

  function automatic logic [DW-1:0] seed_word(input int loc);
    return DW'(16'hA500 ^ (loc * 37));
  endfunction

  function automatic int wrap_inc(input int loc);
    return (loc == DEPTH - 1) ? 0 : loc + 1;
  endfunction

  function automatic int deadline(input int ivl);
    return DEPTH * (ivl + 1) + LATE_LIMIT + RD_CYC + WR_CYC + 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: samples mid-cycle; inputs change just after rising edges
  int            cyc = 0;
  int            seen_epoch = 0;
  int            last_op_cyc = 0;
  bit            last_op_ok = 0;
  int            need = 1;
  int            exp_rf = 0;
  int            last_rf_cyc = 0;
  bit            last_rf_ok = 0;
  bit            rf_active = 0;
  int            rf_loc = 0;
  int            rf_count = 0;
  int            ref_cyc [DEPTH];
  bit            ref_ok  [DEPTH];
  int            q_cyc[$];
  logic [DW-1:0] q_dat[$];

  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      cyc++;
      if (epoch != seen_epoch) begin
        seen_epoch = epoch;
        last_rf_ok = 0;
        for (int i = 0; i < DEPTH; i++) ref_ok[i] = 0;
      end
      if (rf_active) chk(ready == 1'b0, "R5 ready during refresh", ready, 0);
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        chk(rvalid == 1'b1, "R8 rvalid", rvalid, 1);
        chk(rdata == q_dat[0], "R8 rdata", rdata, q_dat[0]);
        void'(q_cyc.pop_front());
        void'(q_dat.pop_front());
      end else begin
        chk(rvalid == 1'b0, "R8 stray rvalid", rvalid, 0);
      end
      if (mem_en) begin
        if (last_op_ok) chk(cyc - last_op_cyc >= need, "R6 recovery", cyc - last_op_cyc, need);
        last_op_ok  = 1;
        last_op_cyc = cyc;
        need        = mem_we ? WR_CYC : RD_CYC;
        if (req && ready) begin
          chk(mem_addr == addr && mem_we == we, "R9 port drive", mem_addr, addr);
          if (we) begin
            chk(mem_wdata == wdata, "R9 write word", mem_wdata, wdata);
            model[addr] = wdata;
          end else begin
            q_cyc.push_back(cyc + 2);
            q_dat.push_back(model[addr]);
          end
        end else if (!mem_we) begin
          chk(int'(mem_addr) == exp_rf, "R3 refresh order", mem_addr, exp_rf);
          exp_rf = wrap_inc(exp_rf);
          if (meas_on) begin
            if (last_rf_ok)
              chk(cyc - last_rf_cyc == int'(rf_interval) + 1, "R2 refresh period",
                  cyc - last_rf_cyc, int'(rf_interval) + 1);
            last_rf_ok  = 1;
            last_rf_cyc = cyc;
          end
          if (ref_ok[mem_addr])
            chk(cyc - ref_cyc[mem_addr] <= deadline(int'(rf_interval)), "R10 deadline",
                cyc - ref_cyc[mem_addr], deadline(int'(rf_interval)));
          ref_ok[mem_addr]  = 1;
          ref_cyc[mem_addr] = cyc;
          rf_active = 1;
          rf_loc    = int'(mem_addr);
          rf_count++;
        end else begin
          chk(rf_active == 1'b1, "R4 write without read", rf_active, 1);
          chk(int'(mem_addr) == rf_loc, "R4 write-back location", mem_addr, rf_loc);
          chk(mem_wdata == model[rf_loc], "R4 write-back word", mem_wdata, model[rf_loc]);
          rf_active = 0;
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic op(input bit w, input int a, input logic [DW-1:0] d);
    req   = 1'b1;
    we    = w;
    addr  = AW'(a);
    wdata = d;
    do @(negedge clk); while (!ready);
    @(posedge clk);
    #1;
    req = 1'b0;
  endtask

  task automatic new_interval(input int ivl);
    meas_on     = 0;
    rf_interval = IW'(ivl);
    epoch++;
    idle(80);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd2024));
    for (int i = 0; i < DEPTH; i++) begin
      ram[i]   = seed_word(i);
      model[i] = seed_word(i);
    end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(ready == 1'b1, "R1 ready", ready, 1);
    chk(mem_en == 1'b0, "R1 mem_en", mem_en, 0);
    chk(rvalid == 1'b0, "R1 rvalid", rvalid, 0);
    rst_n  = 1'b1;
    mon_on = 1;
    @(negedge clk);
    chk(ready == 1'b1 && mem_en == 1'b0 && rvalid == 1'b0, "R1 after release",
        {ready, mem_en, rvalid}, 3'b100);
    @(posedge clk);
    #1;

    // R2: exact period with idle requester, two settings (R3 wrap seen over 20+ steps)
    meas_on = 1;
    idle(300);
    new_interval(25);
    meas_on = 1;
    idle(400);
    meas_on = 0;

    // R9 / R8: directed writes then reads, including the last location
    op(1, 0, 16'h1234);
    op(1, DEPTH - 1, 16'hBEEF);
    op(0, DEPTH - 1, '0);
    op(0, 0, '0);
    op(1, 5, 16'h0F0F);
    op(0, 5, '0);
    idle(10);

    // R7: continuous reads must not starve refresh
    new_interval(20);
    base = rf_count;
    for (int i = 0; i < 150; i++) op(0, i % DEPTH, '0);
    chk(rf_count - base >= 12, "R7 refresh under stream", rf_count - base, 12);

    // mixed random traffic with refresh (R4, R5, R10)
    new_interval(40);
    for (int i = 0; i < 1500; i++) begin
      op(($urandom % 2) == 1, int'($urandom % DEPTH), DW'($urandom));
      idle(int'($urandom % 6));
    end

    // final read-back of every location against the model
    for (int i = 0; i < DEPTH; i++) op(0, i, '0);
    idle(20);
    chk(q_cyc.size() == 0, "R8 outstanding reads", q_cyc.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule